// File: doc/BRIEF.md
# Masked Frame Address Filter

This block sits behind a serial frame receiver and decides, frame by frame, whether the station should keep what follows. When the receiver reports the start of a frame, the filter looks at the one or two address bytes that come next. It compares them against four programmed station address registers, and two mask registers mark which address bits it ignores. A received address of all ones (broadcast) is always taken. A bypass input makes the filter accept every frame, for promiscuous capture.

In narrow mode each of the four registers is a separate 8-bit address. In wide mode the registers pair up into two 16-bit addresses. The decision comes out as a one-cycle strobe with an accept level that holds until the next frame start. For a rejected frame, every later data byte is flagged for discard. A frame that begins while the receiver is disabled gets no comparison, and its bytes are discarded.

Top module: `frame_addr_filter`

## Requirements
- R1: After reset, decisionValid, frameAccept and dataDiscard are all 0 and the filter is idle.
- R2: A frameStart seen while rxEnable is 0 starts no comparison. No decisionValid follows, frameAccept stays 0, and every byte up to the next frameStart raises dataDiscard for one cycle, one cycle after its byteValid.
- R3: In narrow mode (wideMode=0), the first byte after an enabled frameStart is the address. One cycle after that byte, decisionValid pulses for one cycle. At the same time frameAccept becomes 1 if the byte equals any of the four address registers, else 0.
- R4: A 1 in a mask bit makes that address bit don't-care. In narrow mode mask0 covers registers 0 and 1 and mask1 covers registers 2 and 3. In wide mode mask0 covers the first address byte and mask1 covers the second.
- R5: In wide mode (wideMode=1), the first address byte produces no decision. It is compared with registers 0 and 2, and the second byte is compared with registers 1 and 3. The frame is accepted only when both bytes match the same pair (0 with 1, or 2 with 3). The decision appears one cycle after the second byte.
- R6: In wide mode, a mismatch on the first byte is kept. The frame is rejected after the second byte even if the second byte matches.
- R7: An address made entirely of ones (0xFF in narrow mode, 0xFF then 0xFF in wide mode) is accepted whatever the registers and masks hold.
- R8: With bypassAll at 1, every enabled frame is accepted at its decision point.
- R9: After a reject decision, each data byte raises dataDiscard one cycle later, until the next frameStart. After an accept decision, data bytes never raise dataDiscard.
- R10: A frameStart clears frameAccept to 0 one cycle later and restarts the address comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxEnable | input | 1 | Receiver enable, sampled at frame start |
| wideMode | input | 1 | 1 selects 16-bit addresses, 0 selects 8-bit |
| bypassAll | input | 1 | Accept every frame without comparing |
| frameStart | input | 1 | One-cycle pulse at the begin-of-frame flag |
| byteValid | input | 1 | Received byte strobe |
| byteData | input | BYTE_W | Received byte |
| stAddr0 | input | BYTE_W | Station address register 0 |
| stAddr1 | input | BYTE_W | Station address register 1 |
| stAddr2 | input | BYTE_W | Station address register 2 |
| stAddr3 | input | BYTE_W | Station address register 3 |
| addrMask0 | input | BYTE_W | Don't-care mask 0 |
| addrMask1 | input | BYTE_W | Don't-care mask 1 |
| decisionValid | output | 1 | One-cycle pulse when the address decision is made |
| frameAccept | output | 1 | Decision result, held until the next frame start |
| dataDiscard | output | 1 | Pulse marking a byte to drop |

## Verification
Narrow mode is tried with an exact hit on each register pair, with a miss, and with a byte that matches only because of mask bits. Together these separate the per-register comparison from the mask routing between the two pairs. Wide mode is driven with a matching pair, a cross-pair combination, and a bad first byte followed by a good second byte. These show that both bytes must hit the same pair and that an early miss is kept. The all-ones address, the bypass input and a frame that starts while disabled each produce an accept or discard outcome that no ordinary register match could produce.

// File: rtl/frame_addr_filter_pkg.sv
package frame_addr_filter_pkg;
  localparam int unsigned AF_REGS  = 4;
  localparam int unsigned AF_PAIRS = AF_REGS / 2;

  typedef struct packed {
    logic captureFirst;  // latch first-byte hit flags (wide mode)
    logic decideNarrow;  // decision on the single narrow address byte
    logic decideWide;    // decision on the second wide address byte
  } filterStrobe_t;
endpackage

// File: rtl/frame_addr_filter_dp.sv
module frame_addr_filter_dp
  import frame_addr_filter_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  filterStrobe_t     strobe,
  input  logic              bypassAll,
  input  logic [BYTE_W-1:0] byteData,
  input  logic [BYTE_W-1:0] addrRegs [AF_REGS],
  input  logic [BYTE_W-1:0] masks    [AF_PAIRS],
  output logic              acceptNarrow,
  output logic              acceptWide
);
  logic [AF_REGS-1:0]  narrowHit;
  logic [AF_PAIRS-1:0] firstHit;
  logic [AF_PAIRS-1:0] secondHit;
  logic [AF_PAIRS-1:0] heldFirst;
  logic                heldOnes;
  logic                isOnes;

  assign isOnes = &byteData;

  // Narrow comparators: registers 0,1 share mask 0; registers 2,3 share mask 1
  for (genvar i = 0; i < AF_REGS; i++) begin : g_narrow
    localparam int unsigned MI = i / 2;
    assign narrowHit[i] = ((byteData ^ addrRegs[i]) & ~masks[MI]) == '0;
  end

  // Wide comparators: pair p is register 2p (first byte) and 2p+1 (second byte)
  for (genvar p = 0; p < AF_PAIRS; p++) begin : g_wide
    assign firstHit[p]  = ((byteData ^ addrRegs[2*p])   & ~masks[0]) == '0;
    assign secondHit[p] = ((byteData ^ addrRegs[2*p+1]) & ~masks[1]) == '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldFirst <= '0;
      heldOnes  <= 1'b0;
    end else if (strobe.captureFirst) begin
      heldFirst <= firstHit;
      heldOnes  <= isOnes;
    end
  end

  assign acceptNarrow = bypassAll | (|narrowHit) | isOnes;
  assign acceptWide   = bypassAll | (|(heldFirst & secondHit)) | (heldOnes & isOnes);

  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.captureFirst |=> $stable(heldFirst) && $stable(heldOnes)); // R6
endmodule

// File: rtl/frame_addr_filter_ctrl.sv
module frame_addr_filter_ctrl
  import frame_addr_filter_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          rxEnable,
  input  logic          wideMode,
  input  logic          frameStart,
  input  logic          byteValid,
  input  logic          acceptNarrow,
  input  logic          acceptWide,
  output filterStrobe_t strobe,
  output logic          decisionValid,
  output logic          frameAccept,
  output logic          dataDiscard
);
  typedef enum logic [1:0] {ST_IDLE, ST_ADDR_A, ST_ADDR_B, ST_PAYLOAD} filterState_t;
  filterState_t state;
  logic         takeByte;

  assign takeByte = byteValid && !frameStart;

  always_comb begin
    strobe              = '0;
    strobe.captureFirst = takeByte && (state == ST_ADDR_A) && wideMode;
    strobe.decideNarrow = takeByte && (state == ST_ADDR_A) && !wideMode;
    strobe.decideWide   = takeByte && (state == ST_ADDR_B);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state         <= ST_IDLE;
      decisionValid <= 1'b0;
      frameAccept   <= 1'b0;
      dataDiscard   <= 1'b0;
    end else begin
      decisionValid <= 1'b0;
      dataDiscard   <= 1'b0;
      if (frameStart) begin
        state       <= rxEnable ? ST_ADDR_A : ST_IDLE;
        frameAccept <= 1'b0;
      end else if (byteValid) begin
        unique case (state)
          ST_IDLE:    dataDiscard <= 1'b1;
          ST_ADDR_A: begin
            if (wideMode) begin
              state <= ST_ADDR_B;
            end else begin
              state         <= ST_PAYLOAD;
              decisionValid <= 1'b1;
              frameAccept   <= acceptNarrow;
            end
          end
          ST_ADDR_B: begin
            state         <= ST_PAYLOAD;
            decisionValid <= 1'b1;
            frameAccept   <= acceptWide;
          end
          ST_PAYLOAD: dataDiscard <= !frameAccept;
          default:    state <= ST_IDLE;
        endcase
      end
    end
  end

  AST_SINGLE_DECISION: assert property (@(posedge clk) disable iff (!rstN)
    decisionValid |=> !decisionValid); // R3
  AST_WIDE_WAITS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.captureFirst |=> !decisionValid); // R5
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> (!frameAccept && !decisionValid)); // R10
  AST_NO_DISCARD_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    frameAccept |-> !dataDiscard); // R9
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && !rxEnable) |=> (state == ST_IDLE)); // R2
endmodule

// File: rtl/frame_addr_filter.sv
module frame_addr_filter
  import frame_addr_filter_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEnable,
  input  logic              wideMode,
  input  logic              bypassAll,
  input  logic              frameStart,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  input  logic [BYTE_W-1:0] stAddr0,
  input  logic [BYTE_W-1:0] stAddr1,
  input  logic [BYTE_W-1:0] stAddr2,
  input  logic [BYTE_W-1:0] stAddr3,
  input  logic [BYTE_W-1:0] addrMask0,
  input  logic [BYTE_W-1:0] addrMask1,
  output logic              decisionValid,
  output logic              frameAccept,
  output logic              dataDiscard
);
  logic [BYTE_W-1:0] addrRegs [AF_REGS];
  logic [BYTE_W-1:0] masks    [AF_PAIRS];
  filterStrobe_t     strobe;
  logic              acceptNarrow;
  logic              acceptWide;

  assign addrRegs[0] = stAddr0;
  assign addrRegs[1] = stAddr1;
  assign addrRegs[2] = stAddr2;
  assign addrRegs[3] = stAddr3;
  assign masks[0]    = addrMask0;
  assign masks[1]    = addrMask1;

  frame_addr_filter_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .rxEnable     (rxEnable),
    .wideMode     (wideMode),
    .frameStart   (frameStart),
    .byteValid    (byteValid),
    .acceptNarrow (acceptNarrow),
    .acceptWide   (acceptWide),
    .strobe       (strobe),
    .decisionValid(decisionValid),
    .frameAccept  (frameAccept),
    .dataDiscard  (dataDiscard)
  );

  frame_addr_filter_dp #(.BYTE_W(BYTE_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .bypassAll    (bypassAll),
    .byteData     (byteData),
    .addrRegs     (addrRegs),
    .masks        (masks),
    .acceptNarrow (acceptNarrow),
    .acceptWide   (acceptWide)
  );
endmodule

// File: tb/frame_addr_filter_tb.sv
module frame_addr_filter_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxEnable = 1'b0, wideMode = 1'b0, bypassAll = 1'b0;
  logic       frameStart = 1'b0, byteValid = 1'b0;
  logic [7:0] byteData = '0;
  logic [7:0] stAddr0 = 8'h12, stAddr1 = 8'h34, stAddr2 = 8'h56, stAddr3 = 8'h78;
  logic [7:0] addrMask0 = '0, addrMask1 = '0;
  logic       decisionValid, frameAccept, dataDiscard;
  int         errors = 0;
  int         checks = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  frame_addr_filter u_dut (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .wideMode(wideMode),
    .bypassAll(bypassAll), .frameStart(frameStart), .byteValid(byteValid),
    .byteData(byteData), .stAddr0(stAddr0), .stAddr1(stAddr1),
    .stAddr2(stAddr2), .stAddr3(stAddr3), .addrMask0(addrMask0),
    .addrMask1(addrMask1), .decisionValid(decisionValid),
    .frameAccept(frameAccept), .dataDiscard(dataDiscard)
  );

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual{dv,acc,disc}=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic startFrame(input logic en);
    @(negedge clk); frameStart = 1'b1; rxEnable = en;
    @(posedge clk);
    @(negedge clk); frameStart = 1'b0;
  endtask

  // drive a byte, return with outputs settled one cycle after it
  task automatic sendByte(input logic [7:0] b);
    @(negedge clk); byteValid = 1'b1; byteData = b;
    @(posedge clk);
    @(negedge clk); byteValid = 1'b0;
  endtask

  task automatic narrowFrame(input string tag, input logic [7:0] a, input logic acc);
    wideMode = 1'b0;
    startFrame(1'b1);
    chk({tag, " start clears"}, {decisionValid, frameAccept, dataDiscard}, 3'b000);
    sendByte(a);
    chk(tag, {decisionValid, frameAccept, dataDiscard}, {1'b1, acc, 1'b0});
  endtask

  task automatic wideFrame(input string tag, input logic [7:0] a, input logic [7:0] b, input logic acc);
    wideMode = 1'b1;
    startFrame(1'b1);
    sendByte(a);
    chk({tag, " no early decision"}, {decisionValid, frameAccept, dataDiscard}, 3'b000);
    sendByte(b);
    chk(tag, {decisionValid, frameAccept, dataDiscard}, {1'b1, acc, 1'b0});
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R1 reset", {decisionValid, frameAccept, dataDiscard}, 3'b000);
  endtask

  task automatic testNarrow();
    narrowFrame("R3 narrow reg2", 8'h56, 1'b1);
    narrowFrame("R3 narrow reg1", 8'h34, 1'b1);
    narrowFrame("R3 narrow miss", 8'h99, 1'b0);
    sendByte(8'hA5);
    chk("R9 discard after reject", {decisionValid, frameAccept, dataDiscard}, 3'b001);
    sendByte(8'h5A);
    chk("R9 discard second byte", {decisionValid, frameAccept, dataDiscard}, 3'b001);
    narrowFrame("R3 narrow reg3", 8'h78, 1'b1);
    sendByte(8'h00);
    chk("R9 keep after accept", {decisionValid, frameAccept, dataDiscard}, 3'b010);
  endtask

  task automatic testMask();
    addrMask1 = 8'h0F;
    narrowFrame("R4 mask1 on reg2", 8'h5A, 1'b1);
    narrowFrame("R4 mask1 not on reg0", 8'h1F, 1'b0);
    addrMask1 = 8'h00; addrMask0 = 8'h0F;
    narrowFrame("R4 mask0 on reg0", 8'h1F, 1'b1);
    narrowFrame("R4 mask0 high nibble", 8'h22, 1'b0);
    addrMask0 = 8'h00; addrMask1 = 8'hF0;
    wideFrame("R4 wide mask1 second byte", 8'h12, 8'hB4, 1'b1);
    wideFrame("R4 wide mask1 not first", 8'hA2, 8'h34, 1'b0);
    addrMask1 = 8'h00;
  endtask

  task automatic testWide();
    wideFrame("R5 wide pair01", 8'h12, 8'h34, 1'b1);
    wideFrame("R5 wide pair23", 8'h56, 8'h78, 1'b1);
    wideFrame("R5 wide cross pair", 8'h12, 8'h78, 1'b0);
    wideFrame("R6 first miss kept", 8'h99, 8'h34, 1'b0);
    sendByte(8'h11);
    chk("R9 wide discard", {decisionValid, frameAccept, dataDiscard}, 3'b001);
  endtask

  task automatic testOnes();
    narrowFrame("R7 narrow all ones", 8'hFF, 1'b1);
    wideFrame("R7 wide all ones", 8'hFF, 8'hFF, 1'b1);
    wideFrame("R7 wide half ones", 8'hFF, 8'h00, 1'b0);
  endtask

  task automatic testDisabled();
    wideMode = 1'b0;
    startFrame(1'b0);
    sendByte(8'h12);
    chk("R2 disabled no decision", {decisionValid, frameAccept, dataDiscard}, 3'b001);
    sendByte(8'h34);
    chk("R2 disabled second byte", {decisionValid, frameAccept, dataDiscard}, 3'b001);
  endtask

  task automatic testBypass();
    bypassAll = 1'b1;
    narrowFrame("R8 bypass narrow", 8'h99, 1'b1);
    wideFrame("R8 bypass wide", 8'h01, 8'h02, 1'b1);
    bypassAll = 1'b0;
  endtask

  task automatic testRestart();
    narrowFrame("R10 accepted frame", 8'h12, 1'b1);
    sendByte(8'h44);
    chk("R10 accept held", {decisionValid, frameAccept, dataDiscard}, 3'b010);
    startFrame(1'b1);
    chk("R10 start clears accept", {decisionValid, frameAccept, dataDiscard}, 3'b000);
    sendByte(8'h99);
    chk("R10 new comparison", {decisionValid, frameAccept, dataDiscard}, 3'b100);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    testReset();
    testNarrow();
    testMask();
    testWide();
    testOnes();
    testDisabled();
    testBypass();
    testRestart();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule